// File: doc/BRIEF.md
# Per-Line Event Interrupt Controller

This block is the interrupt section of one 32-line general-purpose I/O bank. Each input line is first synchronized, then passed through an optional glitch filter. A per-line detector then watches the resulting sample for a chosen event: a falling edge, a rising edge, either edge, a low level or a high level. Detected events are latched in a status register. Reading that register returns the latched events and clears them in the same access.

A mask register sets which lines may raise the bank's single interrupt output. Software changes the mask only through two write-one-to-act registers, one that enables lines and one that disables them. The event mode and the filter settings come in as per-line configuration inputs from the bank's configuration storage. The slow filter time base comes in as a single-cycle strobe.

Top module: `line_event_irq`

## Requirements
- R1: After reset the status and mask registers read as zero and the interrupt output is low.
- R2: A write to offset 0x20 sets every mask bit whose data bit is 1. Bits written as 0 leave their mask bits unchanged, and no other access changes the mask.
- R3: A write to offset 0x24 clears every mask bit whose data bit is 1. Bits written as 0 leave their mask bits unchanged.
- R4: Offset 0x28 reads the mask. A read at offset 0x2C returns the latched status and clears it at the end of that access cycle.
- R5: An event detected in the same cycle as a status read is not lost. It appears in the following read.
- R6: Line i takes its mode from evt_sel_i[3i+2:3i]. Code 0 latches a falling edge, code 1 a rising edge and code 2 either edge. Each edge is found by comparing the current sample with the previous one.
- R7: Code 3 (low level) and code 4 (high level) re-latch the status bit in every cycle the level holds. The bit therefore reappears after a clearing read for as long as the level persists.
- R8: Codes 5, 6 and 7 never latch an event on that line.
- R9: Events are latched whether or not the line is masked. irq_o is high exactly while some status bit and its mask bit are both 1.
- R10: With the filter off, a pin change reaches the status register, and so irq_o, on the third rising clock edge after the change, through two synchronizer stages.
- R11: When filt_en_i[i] is 1, a change on line i is accepted only after it has stayed stable across two filter strobes. The strobe occurs every cycle when filt_slow_i[i] is 0 and on slow_tick_i when filt_slow_i[i] is 1. Shorter pulses produce no event.
- R12: A read at any offset other than 0x28 or 0x2C returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NLINES | Raw line inputs, asynchronous to clk |
| evt_sel_i | input | 3*NLINES | Per-line event mode, 3 bits per line |
| filt_en_i | input | NLINES | Per-line glitch filter enable |
| filt_slow_i | input | NLINES | Per-line choice of slow filter time base |
| slow_tick_i | input | 1 | One-cycle strobe of the slow filter time base |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | NLINES | Register write data, one bit per line |
| reg_rdata_o | output | NLINES | Register read data, valid in the cycle of the read |
| irq_o | output | 1 | Bank interrupt request |

## Verification
A corrupted mask shows up at the mask read and at irq_o in the cycle after the faulty write. An error in the detector or the filter leaves a wrong bit pattern in the next status read. Those reads are taken a fixed number of cycles after each pin change, so the failing line and mode can be identified. A lost or doubled clear shows up as a missing or stale bit on two reads in a row. The sweeps drive every line through every mode, with the filter both on and off.

// File: rtl/lei_pkg.sv
package lei_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_EN   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_DIS  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h2C;

  typedef enum logic [2:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } ev_sel_e;
endpackage

// File: rtl/lei_sync.sv
module lei_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lei_filter.sv
module lei_filter #(
  parameter int FILT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_i,
  input  logic strobe_i,
  output logic dout_o
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FILT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             out_q, out_d;

  always_comb begin
    cnt_d = cnt_q;
    out_d = out_q;
    if (din_i == out_q) begin
      cnt_d = '0;
    end else if (strobe_i) begin
      if (cnt_q == CNT_LAST) begin
        out_d = din_i;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  assign dout_o = out_q;
endmodule

// File: rtl/lei_detect.sv
module lei_detect
  import lei_pkg::*;
(
  input  logic [2:0] sel_i,
  input  logic       cur_i,
  input  logic       prev_i,
  output logic       hit_o
);
  always_comb begin
    case (sel_i)
      EV_FALL: hit_o = prev_i & ~cur_i;
      EV_RISE: hit_o = ~prev_i & cur_i;
      EV_BOTH: hit_o = prev_i ^ cur_i;
      EV_LOW:  hit_o = ~cur_i;
      EV_HIGH: hit_o = cur_i;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/line_event_irq.sv
module line_event_irq
  import lei_pkg::*;
#(
  parameter int NLINES      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NLINES-1:0]   pin_i,
  input  logic [3*NLINES-1:0] evt_sel_i,
  input  logic [NLINES-1:0]   filt_en_i,
  input  logic [NLINES-1:0]   filt_slow_i,
  input  logic                slow_tick_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [NLINES-1:0]   reg_wdata_i,
  output logic [NLINES-1:0]   reg_rdata_o,
  output logic                irq_o
);
  logic [NLINES-1:0] pin_sync;
  logic [NLINES-1:0] filt_out;
  logic [NLINES-1:0] sample;
  logic [NLINES-1:0] prev_q;
  logic [NLINES-1:0] evt_v;
  logic [NLINES-1:0] imr_q, imr_d;
  logic [NLINES-1:0] stat_q, stat_d;
  logic              imr_we;
  logic              stat_rd;

  lei_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic strobe;
    assign strobe = filt_slow_i[i] ? slow_tick_i : 1'b1;

    lei_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .din_i    (pin_sync[i]),
      .strobe_i (strobe),
      .dout_o   (filt_out[i])
    );

    assign sample[i] = filt_en_i[i] ? filt_out[i] : pin_sync[i];

    lei_detect u_det (
      .sel_i  (evt_sel_i[3*i +: 3]),
      .cur_i  (sample[i]),
      .prev_i (prev_q[i]),
      .hit_o  (evt_v[i])
    );
  end

  // Register access decode
  always_comb begin
    imr_we  = reg_wr_i && ((reg_addr_i == OFS_EN) || (reg_addr_i == OFS_DIS));
    stat_rd = reg_rd_i && (reg_addr_i == OFS_STAT);
    imr_d   = imr_q;
    if (reg_wr_i && (reg_addr_i == OFS_EN))  imr_d = imr_q | reg_wdata_i;
    if (reg_wr_i && (reg_addr_i == OFS_DIS)) imr_d = imr_q & ~reg_wdata_i;
    stat_d  = (stat_rd ? '0 : stat_q) | evt_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q  <= '0;
      stat_q <= '0;
      prev_q <= '0;
    end else begin
      if (imr_we) imr_q <= imr_d;
      stat_q <= stat_d;
      prev_q <= sample;
    end
  end

  always_comb begin
    case (reg_addr_i)
      OFS_MASK: reg_rdata_o = imr_q;
      OFS_STAT: reg_rdata_o = stat_q;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat_q & imr_q);
endmodule

// File: rtl/lei_checker.sv
module lei_checker
  import lei_pkg::*;
#(
  parameter int NLINES = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NLINES-1:0] reg_wdata,
  input logic              irq,
  input logic [NLINES-1:0] imr,
  input logic [NLINES-1:0] st,
  input logic [NLINES-1:0] evt
);
  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_EN) |=> ((imr & $past(reg_wdata)) == $past(reg_wdata))); // R2

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr == OFS_EN || reg_addr == OFS_DIS)) |=> $stable(imr)); // R2

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_DIS) |=> ((imr & $past(reg_wdata)) == '0)); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_STAT) |=> ((st & ~$past(evt)) == '0)); // R4

  AST_READ_KEEPS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_STAT) |=> ((st & $past(evt)) == $past(evt))); // R5

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_addr == OFS_STAT) |=> ((st & $past(st)) == $past(st))); // R9

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == '0) |-> !irq); // R9
endmodule

bind line_event_irq lei_checker #(.NLINES(NLINES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr_i),
  .reg_rd    (reg_rd_i),
  .reg_addr  (reg_addr_i),
  .reg_wdata (reg_wdata_i),
  .irq       (irq_o),
  .imr       (imr_q),
  .st        (stat_q),
  .evt       (evt_v)
);

// File: tb/line_event_irq_tb.sv
module line_event_irq_tb;
  localparam int NL = 32;
  localparam logic [7:0] A_EN = 8'h20, A_DIS = 8'h24, A_MASK = 8'h28, A_STAT = 8'h2C;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NL-1:0]   pin;
  logic [3*NL-1:0] evt_sel;
  logic [NL-1:0]   filt_en, filt_slow;
  logic            slow_tick;
  logic            reg_wr, reg_rd;
  logic [7:0]      reg_addr;
  logic [NL-1:0]   reg_wdata, reg_rdata;
  logic            irq;
  int checks = 0, errors = 0;
  int tcnt = 0;

  always #10 clk = ~clk;

  line_event_irq u_dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .evt_sel_i(evt_sel),
    .filt_en_i(filt_en), .filt_slow_i(filt_slow), .slow_tick_i(slow_tick),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  initial begin
    slow_tick = 1'b0;
    forever begin
      @(negedge clk);
      slow_tick = (tcnt == 3);
      tcnt = (tcnt + 1) % 4;
    end
  end

  task automatic chk(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [NL-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [NL-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m);
    for (int l = 0; l < NL; l++) evt_sel[3*l +: 3] = m;
  endtask

  task automatic flush();
    logic [NL-1:0] d;
    idle(6);
    rd(A_STAT, d);
    rd(A_STAT, d);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [NL-1:0] d;
    rst_n = 1'b0; pin = '0; evt_sel = '0; filt_en = '0; filt_slow = '0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    set_mode(3'd1);
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_MASK, d); chk("R1 mask after reset", d, '0);
    rd(A_STAT, d); chk("R1 status after reset", d, '0);
    chk("R1 irq after reset", {31'd0, irq}, '0);

    // R2 enable writes
    wr(A_EN, 32'hA5A5_0F0F); rd(A_MASK, d); chk("R2 enable set", d, 32'hA5A5_0F0F);
    wr(A_EN, 32'h0000_0030); rd(A_MASK, d); chk("R2 enable or", d, 32'hA5A5_0F3F);
    wr(A_EN, 32'h0);         rd(A_MASK, d); chk("R2 zero write", d, 32'hA5A5_0F3F);
    wr(8'h10, 32'hFFFF_FFFF); rd(A_MASK, d); chk("R2 other offset", d, 32'hA5A5_0F3F);

    // R3 disable writes
    wr(A_DIS, 32'h0000_0F00); rd(A_MASK, d); chk("R3 disable", d, 32'hA5A5_003F);
    wr(A_DIS, 32'h0);         rd(A_MASK, d); chk("R3 zero write", d, 32'hA5A5_003F);

    // R12 unmapped reads
    rd(8'h10, d); chk("R12 unmapped read", d, '0);
    rd(A_EN, d);  chk("R12 enable offset read", d, '0);

    // R6 edge modes, every line
    for (int m = 0; m < 3; m++) begin
      set_mode(3'(m));
      flush();
      for (int l = 0; l < NL; l++) begin
        @(negedge clk); pin[l] = 1'b1;
        idle(5); rd(A_STAT, d);
        chk($sformatf("R6 rise mode%0d line%0d", m, l), d, (m != 0) ? (32'h1 << l) : 32'h0);
        @(negedge clk); pin[l] = 1'b0;
        idle(5); rd(A_STAT, d);
        chk($sformatf("R6 fall mode%0d line%0d", m, l), d, (m != 1) ? (32'h1 << l) : 32'h0);
      end
    end

    // R7 level modes re-latch
    set_mode(3'd3); idle(5);
    rd(A_STAT, d); chk("R7 low level first read", d, '1);
    rd(A_STAT, d); chk("R7 low level re-latch", d, '1);
    @(negedge clk); pin = '1; idle(5);
    rd(A_STAT, d); chk("R7 low level stale", d, '1);
    rd(A_STAT, d); chk("R7 low level gone", d, '0);
    set_mode(3'd4); idle(5);
    rd(A_STAT, d); chk("R7 high level first read", d, '1);
    rd(A_STAT, d); chk("R7 high level re-latch", d, '1);
    @(negedge clk); pin = '0; idle(5);
    rd(A_STAT, d); chk("R7 high level stale", d, '1);
    rd(A_STAT, d); chk("R7 high level gone", d, '0);

    // R8 reserved codes
    for (int m = 5; m < 8; m++) begin
      set_mode(3'(m)); flush();
      @(negedge clk); pin = '1; idle(5);
      @(negedge clk); pin = '0; idle(5);
      rd(A_STAT, d); chk($sformatf("R8 code %0d", m), d, '0);
    end

    // R9 masked lines still latch
    wr(A_DIS, '1); set_mode(3'd1); flush();
    @(negedge clk); pin[3] = 1'b1; idle(5);
    chk("R9 irq masked", {31'd0, irq}, '0);
    wr(A_EN, 32'h8);
    chk("R9 irq after unmask", {31'd0, irq}, 32'h1);
    rd(A_STAT, d); chk("R9 status latched", d, 32'h8);
    chk("R9 irq after clear", {31'd0, irq}, '0);
    @(negedge clk); pin[3] = 1'b0; idle(5);

    // R10 latency
    wr(A_EN, 32'h1);
    @(negedge clk); pin[0] = 1'b1;
    @(posedge clk); #1 chk("R10 edge 1", {31'd0, irq}, '0);
    @(posedge clk); #1 chk("R10 edge 2", {31'd0, irq}, '0);
    @(posedge clk); #1 chk("R10 edge 3", {31'd0, irq}, 32'h1);
    rd(A_STAT, d); chk("R10 status", d, 32'h1);
    @(negedge clk); pin[0] = 1'b0; idle(5);

    // R5 event during read
    @(negedge clk); pin[5] = 1'b1;
    @(negedge clk);
    rd(A_STAT, d); chk("R5 read coinciding", d, '0);
    rd(A_STAT, d); chk("R5 event kept", d, 32'h20);
    @(negedge clk); pin[5] = 1'b0; idle(5);

    // R11 glitch filter
    set_mode(3'd2); flush();
    @(negedge clk); pin[2] = 1'b1; @(negedge clk); pin[2] = 1'b0; idle(8);
    rd(A_STAT, d); chk("R11 unfiltered 1-cycle pulse", d, 32'h4);
    filt_en = '1; flush();
    @(negedge clk); pin[2] = 1'b1; @(negedge clk); pin[2] = 1'b0; idle(8);
    rd(A_STAT, d); chk("R11 fast filter blocks 1 cycle", d, '0);
    @(negedge clk); pin[2] = 1'b1; idle(2); pin[2] = 1'b0; idle(8);
    rd(A_STAT, d); chk("R11 fast filter passes 2 cycles", d, 32'h4);
    filt_slow = '1; flush();
    @(negedge clk); pin[2] = 1'b1; idle(2); pin[2] = 1'b0; idle(16);
    rd(A_STAT, d); chk("R11 slow filter blocks 2 cycles", d, '0);
    @(negedge clk); pin[2] = 1'b1; idle(12); pin[2] = 1'b0; idle(16);
    rd(A_STAT, d); chk("R11 slow filter passes 12 cycles", d, 32'h4);

    summary();
    $finish;
  end
endmodule